// File: doc/BRIEF.md
# Embedded Interval, Fixed-Period and Watchdog Timer Unit

This block supplies the three timers of a small embedded core. A single time-base tick input (`tb_tick`, one cycle wide per tick) advances all of them. A free-running tick counter provides the fixed-period and watchdog intervals through bit taps. A programmable down-counter provides interval interrupts. A control register selects periods, enables and the watchdog reset kind. A status register records expiries and is cleared by writing ones.

Software-side access is a plain single-cycle write port with no back-pressure. `wr_en` with a target select writes the control register, clears status bits, or loads the interval counter. The write takes effect at the clock edge on which it is sampled. The control register, status register and live interval count are always visible on output pins. Every register update, including tick-driven ones, appears on the outputs in the cycle after the edge that sampled the cause. There is no combinational path from any input to any output.

Field positions in both registers are fixed (bit 31 is the most significant bit). Control: 31:30 watchdog period select, 29:28 reset kind, 27 watchdog interrupt enable, 26 interval timer enable, 25:24 fixed-period select, 23 fixed-period interrupt enable, 22 auto-reload. Status: 31 watchdog armed, 30 watchdog interrupt, 29:28 last reset kind, 27 interval expired, 26 fixed period expired.

Top module: `emb_tmr_unit`

## Requirements
- R1: A control write (`wr_sel`=0) stores `wr_data` bits 31:22; control bits 21:0 always read as zero.
- R2: A status write (`wr_sel`=1) clears each status bit among 31:26 whose data bit is 1 and keeps the rest. Status bits 25:0 read zero. A hardware set of a bit on the same edge wins over its clear.
- R3: The fixed-period event occurs on ticks numbered k·2^(FIT_BASE+FIT_STEP·s), counted from reset, where s is control bits 25:24. Each such event sets status bit 26.
- R4: `fit_irq` equals status 26 AND control 23. `pit_irq` equals status 27 AND control 26. `wdt_irq` equals status 30 AND control 27.
- R5: An interval write (`wr_sel`=2) sets both reload value and count to `wr_data` and arms the timer only if the value exceeds 1. While armed and control 26 is set, each tick decrements the count. Otherwise the count holds. A load on the same edge as a tick wins.
- R6: A tick seen at count 1 sets status 27. With control 22 set, the count returns to the reload value and keeps running. Without it, the count becomes 0 and the timer disarms.
- R7: The watchdog event occurs on ticks numbered k·2^(WDT_BASE+WDT_STEP·w), where w is control bits 31:30.
- R8: A watchdog event with status 31 clear sets 31. With 31 set and 30 clear, it sets 30.
- R9: A watchdog event with status 31 and 30 both set copies control 29:28 into status 29:28. It also emits a one-cycle pulse on the reset output selected by that kind: 1 core, 2 chip, 3 system, 0 none.
- R10: A write with `wr_sel`=3 changes no register.
- R11: After reset, all registers, the tick counter, the interrupts and the reset pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 control, 1 status clear, 2 interval load, 3 none |
| wr_data | input | 32 | Write data |
| tcr_q | output | 32 | Control register |
| tsr_q | output | 32 | Status register |
| pit_count | output | 32 | Live interval count |
| pit_irq | output | 1 | Interval interrupt |
| fit_irq | output | 1 | Fixed-period interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |
| rst_core_req | output | 1 | Core reset pulse |
| rst_chip_req | output | 1 | Chip reset pulse |
| rst_sys_req | output | 1 | System reset pulse |

## Verification
The bench builds the unit with FIT_BASE=2, FIT_STEP=2, WDT_BASE=4 and WDT_STEP=2. This gives fixed periods of 4 to 256 ticks and watchdog periods of 16 to 1024 ticks. With these values, the full three-stage watchdog escalation for every reset kind fits in a few hundred cycles. So do several periods of each select and a wrap of the 10-bit tick counter. The short fixed period also makes a status clear land on the same edge as a fresh expiry, which exercises the set-over-clear rule.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PIT  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CORE = 2'd1,
    KIND_CHIP = 2'd2,
    KIND_SYS  = 2'd3
  } rst_kind_e;

  // control field positions
  localparam int C_WDP_HI  = 31;
  localparam int C_WDP_LO  = 30;
  localparam int C_KIND_HI = 29;
  localparam int C_KIND_LO = 28;
  localparam int C_WDIE    = 27;
  localparam int C_PIE     = 26;
  localparam int C_FP_HI   = 25;
  localparam int C_FP_LO   = 24;
  localparam int C_FIE     = 23;
  localparam int C_ARL     = 22;

  // status field positions
  localparam int S_ARM     = 31;
  localparam int S_WDI     = 30;
  localparam int S_KIND_HI = 29;
  localparam int S_KIND_LO = 28;
  localparam int S_PIS     = 27;
  localparam int S_FIS     = 26;

  localparam int CTRL_LSB  = 22;
  localparam int STAT_LSB  = 26;
endpackage

// File: rtl/emb_tmr_taps.sv
module emb_tmr_taps #(
  parameter int FIT_BASE = 9,
  parameter int FIT_STEP = 4,
  parameter int WDT_BASE = 17,
  parameter int WDT_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] fit_sel,
  input  logic [1:0] wdt_sel,
  output logic       fit_hit,
  output logic       wdt_hit
);
  localparam int FIT_TOP = FIT_BASE + 3 * FIT_STEP;
  localparam int WDT_TOP = WDT_BASE + 3 * WDT_STEP;
  localparam int FREE_W  = (FIT_TOP > WDT_TOP) ? FIT_TOP : WDT_TOP;

  logic [FREE_W-1:0] free_cnt;
  logic [3:0]        fit_lvl;
  logic [3:0]        wdt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    free_cnt <= '0;
    else if (tick) free_cnt <= free_cnt + 1'b1;
  end

  // an interval of 2^w ends on the tick that sees the low w bits all ones
  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int FW = FIT_BASE + FIT_STEP * g;
    localparam int WW = WDT_BASE + WDT_STEP * g;
    assign fit_lvl[g] = &free_cnt[FW-1:0];
    assign wdt_lvl[g] = &free_cnt[WW-1:0];
  end

  assign fit_hit = tick & fit_lvl[fit_sel];
  assign wdt_hit = tick & wdt_lvl[wdt_sel];

  // R3 / R7: hits only come with a tick
  a_r3_hit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (fit_hit || wdt_hit) |-> tick);
  a_r3_counter_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(free_cnt));
endmodule

// File: rtl/emb_tmr_pit.sv
module emb_tmr_pit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         enable,
  input  logic         auto_reload,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] reload_r;
  logic         run_r;
  logic         step;

  assign step   = tick & run_r & enable & ~load_en;
  assign expire = step & (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_r <= '0;
      count    <= '0;
      run_r    <= 1'b0;
    end else if (load_en) begin
      reload_r <= load_val;
      count    <= load_val;
      run_r    <= (load_val > W'(1));
    end else if (step) begin
      if (count == W'(1)) begin
        count <= auto_reload ? reload_r : '0;
        run_r <= auto_reload;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  a_r5_hold_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !tick) |=> $stable(count));
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count == $past(load_val));
  a_r6_one_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_reload) |=> (count == '0) && !run_r);
endmodule

// File: rtl/emb_tmr_wdog.sv
module emb_tmr_wdog
  import emb_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       armed,
  input  logic       flagged,
  input  logic [1:0] kind,
  output logic       set_arm,
  output logic       set_flag,
  output logic       fire,
  output logic       rst_core,
  output logic       rst_chip,
  output logic       rst_sys
);
  rst_kind_e kind_e;
  assign kind_e   = rst_kind_e'(kind);
  assign set_arm  = hit & ~armed;
  assign set_flag = hit & armed & ~flagged;
  assign fire     = hit & armed & flagged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_core <= 1'b0;
      rst_chip <= 1'b0;
      rst_sys  <= 1'b0;
    end else begin
      rst_core <= fire && (kind_e == KIND_CORE);
      rst_chip <= fire && (kind_e == KIND_CHIP);
      rst_sys  <= fire && (kind_e == KIND_SYS);
    end
  end

  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_core, rst_chip, rst_sys}));
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core || rst_chip || rst_sys) |=> !(rst_core || rst_chip || rst_sys));
  a_r9_needs_both_stages: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sys) |-> $past(armed && flagged && hit));
endmodule

// File: rtl/emb_tmr_unit.sv
module emb_tmr_unit
  import emb_tmr_pkg::*;
#(
  parameter int FIT_BASE = 9,
  parameter int FIT_STEP = 4,
  parameter int WDT_BASE = 17,
  parameter int WDT_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tb_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] tcr_q,
  output logic [31:0] tsr_q,
  output logic [31:0] pit_count,
  output logic        pit_irq,
  output logic        fit_irq,
  output logic        wdt_irq,
  output logic        rst_core_req,
  output logic        rst_chip_req,
  output logic        rst_sys_req
);
  localparam int CTRL_N = REG_W - CTRL_LSB;
  localparam int STAT_N = REG_W - STAT_LSB;

  wr_sel_e sel_e;
  logic [CTRL_N-1:0] ctrl_r;
  logic [STAT_N-1:0] stat_r;
  logic [STAT_N-1:0] stat_n;
  logic [STAT_N-1:0] clr;
  logic wr_ctrl, wr_stat, wr_pit;
  logic fit_hit, wdt_hit, pit_exp;
  logic set_arm, set_flag, fire;

  assign sel_e   = wr_sel_e'(wr_sel);
  assign wr_ctrl = wr_en && (sel_e == SEL_CTRL);
  assign wr_stat = wr_en && (sel_e == SEL_STAT);
  assign wr_pit  = wr_en && (sel_e == SEL_PIT);

  assign tcr_q = {ctrl_r, {CTRL_LSB{1'b0}}};
  assign tsr_q = {stat_r, {STAT_LSB{1'b0}}};

  emb_tmr_taps #(
    .FIT_BASE(FIT_BASE), .FIT_STEP(FIT_STEP),
    .WDT_BASE(WDT_BASE), .WDT_STEP(WDT_STEP)
  ) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tb_tick),
    .fit_sel (tcr_q[C_FP_HI:C_FP_LO]),
    .wdt_sel (tcr_q[C_WDP_HI:C_WDP_LO]),
    .fit_hit (fit_hit),
    .wdt_hit (wdt_hit)
  );

  emb_tmr_pit #(.W(REG_W)) u_pit (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tb_tick),
    .load_en     (wr_pit),
    .load_val    (wr_data),
    .enable      (tcr_q[C_PIE]),
    .auto_reload (tcr_q[C_ARL]),
    .count       (pit_count),
    .expire      (pit_exp)
  );

  emb_tmr_wdog u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (wdt_hit),
    .armed    (tsr_q[S_ARM]),
    .flagged  (tsr_q[S_WDI]),
    .kind     (tcr_q[C_KIND_HI:C_KIND_LO]),
    .set_arm  (set_arm),
    .set_flag (set_flag),
    .fire     (fire),
    .rst_core (rst_core_req),
    .rst_chip (rst_chip_req),
    .rst_sys  (rst_sys_req)
  );

  assign clr = wr_stat ? wr_data[REG_W-1:STAT_LSB] : '0;

  always_comb begin
    stat_n = stat_r & ~clr;
    if (fit_hit)  stat_n[S_FIS - STAT_LSB] = 1'b1;
    if (pit_exp)  stat_n[S_PIS - STAT_LSB] = 1'b1;
    if (set_arm)  stat_n[S_ARM - STAT_LSB] = 1'b1;
    if (set_flag) stat_n[S_WDI - STAT_LSB] = 1'b1;
    if (fire)
      stat_n[S_KIND_HI-STAT_LSB:S_KIND_LO-STAT_LSB] = tcr_q[C_KIND_HI:C_KIND_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      stat_r <= '0;
    end else begin
      stat_r <= stat_n;
      if (wr_ctrl) ctrl_r <= wr_data[REG_W-1:CTRL_LSB];
    end
  end

  assign fit_irq = tsr_q[S_FIS] & tcr_q[C_FIE];
  assign pit_irq = tsr_q[S_PIS] & tcr_q[C_PIE];
  assign wdt_irq = tsr_q[S_WDI] & tcr_q[C_WDIE];

  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> tcr_q == ($past(wr_data) & 32'hFFC0_0000));
  a_r2_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[S_PIS] && !pit_exp) |=> !tsr_q[S_PIS]);
  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsr_q[S_WDI]) |-> $past(tsr_q[S_ARM]));
  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_e == SEL_NONE) |=> $stable(tcr_q));
endmodule

// File: tb/test_emb_tmr_unit.sv
module test_emb_tmr_unit;
  localparam int FB = 2, FS = 2, WB = 4, WS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] tcr_q, tsr_q, pit_count;
  logic        pit_irq, fit_irq, wdt_irq, rst_core_req, rst_chip_req, rst_sys_req;

  always #5 clk = ~clk;

  emb_tmr_unit #(.FIT_BASE(FB), .FIT_STEP(FS), .WDT_BASE(WB), .WDT_STEP(WS)) i_emb_tmr_unit (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tcr_q(tcr_q), .tsr_q(tsr_q), .pit_count(pit_count),
    .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
    .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req), .rst_sys_req(rst_sys_req)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R11";

  // behavioural reference
  logic [31:0] m_tcr = '0, m_tsr = '0, m_cnt = '0, m_rel = '0;
  bit m_run = 0, m_core = 0, m_chip = 0, m_sys = 0;
  longint n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tcr = '0; m_tsr = '0; m_cnt = '0; m_rel = '0; m_run = 0;
      m_core = 0; m_chip = 0; m_sys = 0; n = 0;
    end else begin
      logic [31:0] nt;
      longint pf, pw;
      bit fh, wh;
      pf = longint'(1) << (FB + FS * int'(m_tcr[25:24]));
      pw = longint'(1) << (WB + WS * int'(m_tcr[31:30]));
      fh = tb_tick && (n % pf == pf - 1);
      wh = tb_tick && (n % pw == pw - 1);
      nt = m_tsr;
      if (wr_en && wr_sel == 2'd1) nt = nt & ~(wr_data & 32'hFC00_0000);
      if (fh) nt[26] = 1'b1;
      m_core = 0; m_chip = 0; m_sys = 0;
      if (wr_en && wr_sel == 2'd2) begin
        m_rel = wr_data; m_cnt = wr_data; m_run = (wr_data > 32'd1);
      end else if (tb_tick && m_run && m_tcr[26]) begin
        if (m_cnt == 32'd1) begin
          nt[27] = 1'b1;
          if (m_tcr[22]) m_cnt = m_rel;
          else begin m_cnt = 0; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (wh) begin
        if (!m_tsr[31]) nt[31] = 1'b1;
        else if (!m_tsr[30]) nt[30] = 1'b1;
        else begin
          nt[29:28] = m_tcr[29:28];
          m_core = (m_tcr[29:28] == 2'd1);
          m_chip = (m_tcr[29:28] == 2'd2);
          m_sys  = (m_tcr[29:28] == 2'd3);
        end
      end
      m_tsr = nt;
      if (wr_en && wr_sel == 2'd0) m_tcr = wr_data & 32'hFFC0_0000;
      if (tb_tick) n = n + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 tcr", tcr_q, m_tcr);
      chk("R2 tsr", tsr_q, m_tsr);
      chk("R5 pit_count", pit_count, m_cnt);
      chk("R4 irqs", {29'd0, pit_irq, fit_irq, wdt_irq},
          {29'd0, m_tsr[27] & m_tcr[26], m_tsr[26] & m_tcr[23], m_tsr[30] & m_tcr[27]});
      chk("R9 resets", {29'd0, rst_core_req, rst_chip_req, rst_sys_req},
          {29'd0, m_core, m_chip, m_sys});
    end
  end

  task automatic cyc(bit t, bit we, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    tb_tick = t; wr_en = we; wr_sel = s; wr_data = d;
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) cyc(1'b1, 1'b0, 2'd0, '0);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    cyc(1'b0, 1'b1, s, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL timeout (all requirements): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R11";
    chk("R11 reset", {tcr_q[31:0] | tsr_q | pit_count}, 32'd0);
    chk("R11 reset outs", {26'd0, pit_irq, fit_irq, wdt_irq,
        rst_core_req, rst_chip_req, rst_sys_req}, 32'd0);

    phase = "R1";
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0000_0000);
    wr(2'd0, 32'h5A5A_5A5A);
    phase = "R10";
    wr(2'd3, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 2'd0, '0);
    chk("R10 ctrl kept", tcr_q, 32'h5A40_0000);
    chk("R10 count kept", pit_count, 32'd0);
    wr(2'd0, 32'h0);

    phase = "R3";
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 32'h0080_0000 | (32'(s) << 24));
      run(70 << (2 * s));
      wr(2'd1, 32'hFC00_0000);
    end
    wr(2'd0, 32'h0080_0000);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 2'd1, 32'h0400_0000);
    wr(2'd1, 32'hFC00_0000);

    phase = "R6";
    wr(2'd0, 32'h0440_0000);
    wr(2'd2, 32'd5);
    run(23);
    wr(2'd1, 32'hFC00_0000);
    wr(2'd0, 32'h0400_0000);
    wr(2'd2, 32'd3);
    run(8);
    phase = "R5";
    wr(2'd2, 32'd1);
    run(5);
    wr(2'd2, 32'd0);
    run(5);
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'd6);
    run(8);
    wr(2'd0, 32'h0400_0000);
    run(4);
    cyc(1'b1, 1'b1, 2'd2, 32'd9);
    run(12);
    for (int i = 0; i < 60; i++) cyc(i % 3 != 0, 1'b0, 2'd0, '0);
    wr(2'd1, 32'hFC00_0000);

    phase = "R8";
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 32'h0800_0000 | (32'(k) << 28));
      wr(2'd1, 32'hFC00_0000);
      run(70);
    end
    phase = "R7";
    wr(2'd0, 32'h7800_0000);
    wr(2'd1, 32'hFC00_0000);
    run(200);
    wr(2'd0, 32'hB800_0000);
    wr(2'd1, 32'hFC00_0000);
    run(800);
    for (int i = 0; i < 300; i++) cyc(i % 3 != 0, 1'b0, 2'd0, '0);
    cyc(1'b0, 1'b0, 2'd0, '0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule